// File: doc/BRIEF.md
# Width-aware byte data FIFO

This block sits between a 32-bit processor bus and a byte-wide card data stream. It keeps a 32-byte receive queue filled from the card and a transmit queue drained toward the card. The transmit queue sits in a 64-byte store that is split into two 32-byte halves. Processor reads and writes may be 1, 2 or 4 bytes wide. The block unpacks each write into single bytes and packs bytes into each read, with the earliest byte placed in the highest lane of the access.

A command sequencer starts a transfer and gives its direction. The block then loads a byte counter with the block count times the block length and moves at most one byte per clock across a valid/ready card port. While data is moving it raises service requests toward the processor. At the end it emits completion pulses for the interrupt router. A separate strobe moves the transmit read side to the other half of the store and drops whatever was queued there.

Top module: `byte_fifo_xfer`

## Requirements
- R1: After reset, `xfer_active`, `rx_req`, `tx_req`, `data_done`, `prog_done`, `card_rx_ready` and `card_tx_valid` are 0, both queues are empty, and a 4-byte read returns 0.
- R2: A read with `bus_width` code 0, 1 or 2 (3 acts as 2) pops up to 1, 2 or 4 bytes. The first byte popped lands in the highest lane of that width, later bytes land in lower lanes, and lanes without data read 0. `rd_data` is valid on the clock edge after `rd_strobe`.
- R3: The receive queue holds 32 bytes. With 32 bytes queued, `card_rx_ready` is 0 and no card byte is taken.
- R4: A write of width N pushes bytes from lane N-1 down to lane 0. Pushing stops once 32 bytes are queued, and the card receives the bytes in push order.
- R5: Each byte accepted from the card sets `rx_req`. A read clears it, except that a byte accepted in the same cycle keeps it set.
- R6: `tx_req` is set in every cycle of a write-direction transfer that still has bytes left, and a bus write clears it.
- R7: At `xfer_start` the counter loads `blk_count` x `blk_len`. Each card handshake moves one byte and decrements it. The card port of the direction not in use stays idle, and no handshake occurs once the count is 0.
- R8: When the count is 0 in an active transfer, `xfer_active` falls and `data_done` pulses for one cycle. In write direction `prog_done` pulses with it. A zero-length transfer completes this way straight away.
- R9: `flip_strobe` moves the transmit read side to the other 32-byte half and empties the transmit queue, so only bytes written afterwards reach the card.
- R10: `xfer_start` empties both queues, so no byte left from earlier reaches a later read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_width | input | 2 | Access width code: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| rd_strobe | input | 1 | Pop from the receive queue |
| rd_data | output | 32 | Packed read result, registered |
| wr_strobe | input | 1 | Push to the transmit queue |
| wr_data | input | 32 | Write data to unpack |
| flip_strobe | input | 1 | Switch transmit half and empty it |
| xfer_start | input | 1 | Start a transfer |
| xfer_write | input | 1 | Direction at start: 1 = toward card |
| blk_count | input | 16 | Number of blocks |
| blk_len | input | 12 | Bytes per block |
| card_tx_data | output | 8 | Byte toward the card |
| card_tx_valid | output | 1 | Transmit byte available |
| card_tx_ready | input | 1 | Card takes the transmit byte |
| card_rx_data | input | 8 | Byte from the card |
| card_rx_valid | input | 1 | Card byte available |
| card_rx_ready | output | 1 | Block accepts a card byte |
| rx_req | output | 1 | Receive service request |
| tx_req | output | 1 | Transmit service request |
| data_done | output | 1 | One-cycle transfer completion pulse |
| prog_done | output | 1 | One-cycle write completion pulse |
| xfer_active | output | 1 | Transfer in progress |

## Verification
`rd_data`, `rx_req`, `tx_req` and the queue counts change on the first edge after their stimulus, so the bench drives on the falling edge and reads one falling edge later. The card handshake signals are combinational from the registered state, and transmit bytes are logged on the rising edge where the handshake occurs. `data_done` and `prog_done` rise on the second edge after the last byte moves, so the bench waits three cycles before it compares pulse counts. Completion and byte order are judged from those logs and counters rather than from any single cycle.

// File: rtl/bfx_pkg.sv
// Shared constants and the access-width decode for the byte data FIFO.
// Assumes a 32-bit bus made of four byte lanes.
package bfx_pkg;
    localparam int BUS_LANES = 4;
    localparam int NW        = 3;   // bits for a byte count of 0..BUS_LANES

    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_HALF = 2'd1,
        ACC_WORD = 2'd2,
        ACC_WALT = 2'd3
    } acc_width_e;

    // Number of bytes an access of the given width code moves.
    function automatic logic [NW-1:0] width_bytes(input logic [1:0] code);
        case (acc_width_e'(code))
            ACC_BYTE: width_bytes = NW'(1);
            ACC_HALF: width_bytes = NW'(2);
            default:  width_bytes = NW'(4);
        endcase
    endfunction
endpackage

// File: rtl/bfx_rx_fifo.sv
// Receive byte queue: pushes one card byte per clock and pops up to
// BUS_LANES bytes per read, packing the earliest byte into the highest lane
// of the access. Assumes the caller pushes only when not full.
module bfx_rx_fifo
    import bfx_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic                   push,
    input  logic [7:0]             push_data,
    input  logic                   pop,
    input  logic [NW-1:0]          pop_n,
    output logic [BUS_LANES*8-1:0] pop_word,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] rd_ptr;
    logic [CW-1:0] cnt;
    logic [NW-1:0] taken;
    logic [AW-1:0] wr_ptr;

    assign count  = cnt;
    assign wr_ptr = AW'(rd_ptr + cnt[AW-1:0]);

    // Gather the bytes a pop of pop_n would take, highest lane first.
    always_comb begin
        pop_word = '0;
        taken    = '0;
        for (int i = 0; i < BUS_LANES; i++) begin
            if (i < int'(pop_n) && i < int'(cnt)) begin
                pop_word[(int'(pop_n)-1-i)*8 +: 8] = mem[AW'(rd_ptr + AW'(i))];
                taken = taken + NW'(1);
            end
        end
    end

    // Byte storage write.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    // Read pointer and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            cnt    <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else begin
            if (pop) rd_ptr <= AW'(rd_ptr + AW'(taken));
            cnt <= cnt - (pop ? CW'(taken) : CW'(0)) + CW'(push);
        end
    end
endmodule

// File: rtl/bfx_tx_fifo.sv
// Transmit byte queue in a store of two halves. Writes unpack up to
// BUS_LANES bytes from the highest lane down, wrapping inside the current
// half; the card pops one byte per clock. A flip moves the read side to the
// other half and empties the queue. Assumes pop only when count is nonzero.
module bfx_tx_fifo
    import bfx_pkg::*;
#(
    parameter int HALF = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic                   flip,
    input  logic                   wr_en,
    input  logic [NW-1:0]          wr_n,
    input  logic [BUS_LANES*8-1:0] wr_word,
    input  logic                   pop,
    output logic [7:0]             head,
    output logic [$clog2(HALF+1)-1:0] count
);
    localparam int AW = $clog2(HALF);
    localparam int CW = $clog2(HALF+1);

    logic [7:0]    mem [2*HALF];
    logic [AW:0]   rd_ptr;
    logic [CW-1:0] cnt;
    logic          wen   [BUS_LANES];
    logic [AW:0]   waddr [BUS_LANES];
    logic [7:0]    wbyte [BUS_LANES];
    logic [NW-1:0] npush;

    assign count = cnt;
    assign head  = mem[rd_ptr];

    // Lane-to-slot mapping for a write, stopping when the half is full.
    always_comb begin
        npush = '0;
        for (int j = 0; j < BUS_LANES; j++) begin
            wen[j]   = wr_en && (j < int'(wr_n)) && (int'(cnt) + j < HALF);
            waddr[j] = {rd_ptr[AW], AW'(rd_ptr[AW-1:0] + cnt[AW-1:0] + AW'(j))};
            wbyte[j] = (j < int'(wr_n)) ? wr_word[(int'(wr_n)-1-j)*8 +: 8] : 8'h00;
            if (wen[j]) npush = npush + NW'(1);
        end
    end

    // Byte storage write, one slot per accepted lane.
    always_ff @(posedge clk) begin
        for (int j = 0; j < BUS_LANES; j++) begin
            if (wen[j]) mem[waddr[j]] <= wbyte[j];
        end
    end

    // Read pointer, half select and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            cnt    <= '0;
        end else if (flip) begin
            rd_ptr[AW] <= ~rd_ptr[AW];
            cnt        <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else begin
            if (pop) rd_ptr[AW-1:0] <= AW'(rd_ptr[AW-1:0] + AW'(1));
            cnt <= cnt - CW'(pop) + CW'(npush);
        end
    end
endmodule

// File: rtl/bfx_xfer_ctl.sv
// Transfer byte counter: loads count x length at start, steps down once per
// card beat, and ends the transfer with done pulses. Assumes beat is only
// raised while the count is nonzero.
module bfx_xfer_ctl #(
    parameter int CNT_W  = 16,
    parameter int LEN_W  = 12,
    parameter int LEFT_W = CNT_W + LEN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dir_wr,
    input  logic [CNT_W-1:0]  blk_count,
    input  logic [LEN_W-1:0]  blk_len,
    input  logic              beat,
    output logic              active,
    output logic              dir_q,
    output logic [LEFT_W-1:0] left,
    output logic              data_done,
    output logic              prog_done
);
    // Counter, direction and completion pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            dir_q     <= 1'b0;
            left      <= '0;
            data_done <= 1'b0;
            prog_done <= 1'b0;
        end else begin
            data_done <= 1'b0;
            prog_done <= 1'b0;
            if (start) begin
                active <= 1'b1;
                dir_q  <= dir_wr;
                left   <= LEFT_W'(blk_count) * LEFT_W'(blk_len);
            end else if (active) begin
                if (left == '0) begin
                    active    <= 1'b0;
                    data_done <= 1'b1;
                    prog_done <= dir_q;
                end else if (beat) begin
                    left <= left - LEFT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/byte_fifo_xfer.sv
// Top of the byte data FIFO: joins the receive queue, the two-half transmit
// queue and the transfer counter, drives the card handshake and holds the
// service requests. Assumes bus strobes are single-cycle pulses.
module byte_fifo_xfer
    import bfx_pkg::*;
#(
    parameter int RX_DEPTH = 32,
    parameter int TX_HALF  = 32,
    parameter int CNT_W    = 16,
    parameter int LEN_W    = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             bus_width,
    input  logic                   rd_strobe,
    output logic [BUS_LANES*8-1:0] rd_data,
    input  logic                   wr_strobe,
    input  logic [BUS_LANES*8-1:0] wr_data,
    input  logic                   flip_strobe,
    input  logic                   xfer_start,
    input  logic                   xfer_write,
    input  logic [CNT_W-1:0]       blk_count,
    input  logic [LEN_W-1:0]       blk_len,
    output logic [7:0]             card_tx_data,
    output logic                   card_tx_valid,
    input  logic                   card_tx_ready,
    input  logic [7:0]             card_rx_data,
    input  logic                   card_rx_valid,
    output logic                   card_rx_ready,
    output logic                   rx_req,
    output logic                   tx_req,
    output logic                   data_done,
    output logic                   prog_done,
    output logic                   xfer_active
);
    localparam int LEFT_W = CNT_W + LEN_W;
    localparam int RCW    = $clog2(RX_DEPTH+1);
    localparam int TCW    = $clog2(TX_HALF+1);

    logic [NW-1:0]          acc_n;
    logic [BUS_LANES*8-1:0] pop_word;
    logic [RCW-1:0]         rx_cnt;
    logic [TCW-1:0]         tx_cnt;
    logic [LEFT_W-1:0]      left;
    logic                   dir_q;
    logic                   left_nz;
    logic                   rx_push;
    logic                   tx_pop;

    assign acc_n         = width_bytes(bus_width);
    assign left_nz       = (left != '0);
    assign card_rx_ready = xfer_active && !dir_q && left_nz && (int'(rx_cnt) < RX_DEPTH);
    assign card_tx_valid = xfer_active && dir_q && left_nz && (tx_cnt != '0);
    assign rx_push       = card_rx_valid && card_rx_ready;
    assign tx_pop        = card_tx_valid && card_tx_ready;

    bfx_rx_fifo #(.DEPTH(RX_DEPTH)) u_rx (
        .clk(clk), .rst_n(rst_n), .clear(xfer_start),
        .push(rx_push), .push_data(card_rx_data),
        .pop(rd_strobe), .pop_n(acc_n), .pop_word(pop_word), .count(rx_cnt)
    );

    bfx_tx_fifo #(.HALF(TX_HALF)) u_tx (
        .clk(clk), .rst_n(rst_n), .clear(xfer_start), .flip(flip_strobe),
        .wr_en(wr_strobe), .wr_n(acc_n), .wr_word(wr_data),
        .pop(tx_pop), .head(card_tx_data), .count(tx_cnt)
    );

    bfx_xfer_ctl #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_ctl (
        .clk(clk), .rst_n(rst_n), .start(xfer_start), .dir_wr(xfer_write),
        .blk_count(blk_count), .blk_len(blk_len), .beat(rx_push || tx_pop),
        .active(xfer_active), .dir_q(dir_q), .left(left),
        .data_done(data_done), .prog_done(prog_done)
    );

    // Registered read result and the two service requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            rx_req  <= 1'b0;
            tx_req  <= 1'b0;
        end else begin
            if (rd_strobe) rd_data <= pop_word;
            if (rx_push)        rx_req <= 1'b1;
            else if (rd_strobe) rx_req <= 1'b0;
            if (wr_strobe)                           tx_req <= 1'b0;
            else if (xfer_active && dir_q && left_nz) tx_req <= 1'b1;
        end
    end
endmodule

// File: rtl/bfx_chk.sv
// Property checker for the byte data FIFO, attached to the top by bind.
// Assumes the counts and counter it watches are the top's internal nets.
module bfx_chk #(
    parameter int RX_DEPTH = 32,
    parameter int TX_HALF  = 32,
    parameter int LEFT_W   = 28
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [$clog2(RX_DEPTH+1)-1:0] rx_cnt,
    input logic [$clog2(TX_HALF+1)-1:0]  tx_cnt,
    input logic [LEFT_W-1:0]             left,
    input logic                          xfer_active,
    input logic                          xfer_start,
    input logic                          card_rx_valid,
    input logic                          card_rx_ready,
    input logic                          card_tx_valid,
    input logic                          card_tx_ready,
    input logic                          rx_req,
    input logic                          wr_strobe,
    input logic                          tx_req,
    input logic                          data_done,
    input logic                          prog_done
);
    // R3
    rx_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(rx_cnt) <= RX_DEPTH);
    // R4
    tx_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(tx_cnt) <= TX_HALF);
    // R5
    rx_req_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (card_rx_valid && card_rx_ready) |=> rx_req);
    // R6
    tx_req_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |=> !tx_req);
    // R7
    left_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_active && !xfer_start && ((card_rx_valid && card_rx_ready) ||
         (card_tx_valid && card_tx_ready))) |=> (left == $past(left) - LEFT_W'(1)));
    // R7
    one_direction_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(card_rx_ready && card_tx_valid));
    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_done |-> !xfer_active);
    // R8
    prog_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_done |-> data_done);
endmodule

bind byte_fifo_xfer bfx_chk #(.RX_DEPTH(RX_DEPTH), .TX_HALF(TX_HALF), .LEFT_W(LEFT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_cnt(rx_cnt), .tx_cnt(tx_cnt), .left(left),
    .xfer_active(xfer_active), .xfer_start(xfer_start),
    .card_rx_valid(card_rx_valid), .card_rx_ready(card_rx_ready),
    .card_tx_valid(card_tx_valid), .card_tx_ready(card_tx_ready),
    .rx_req(rx_req), .wr_strobe(wr_strobe), .tx_req(tx_req),
    .data_done(data_done), .prog_done(prog_done)
);

// File: tb/sim_byte_fifo_xfer.sv
module sim_byte_fifo_xfer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_width = 2'd0;
    logic        rd_strobe = 1'b0;
    logic [31:0] rd_data;
    logic        wr_strobe = 1'b0;
    logic [31:0] wr_data = '0;
    logic        flip_strobe = 1'b0;
    logic        xfer_start = 1'b0;
    logic        xfer_write = 1'b0;
    logic [15:0] blk_count = '0;
    logic [11:0] blk_len = '0;
    logic [7:0]  card_tx_data;
    logic        card_tx_valid;
    logic        card_tx_ready = 1'b0;
    logic [7:0]  card_rx_data = '0;
    logic        card_rx_valid = 1'b0;
    logic        card_rx_ready;
    logic        rx_req, tx_req, data_done, prog_done, xfer_active;

    int checks = 0;
    int errors = 0;
    int txn = 0;
    int dd_cnt = 0;
    int pd_cnt = 0;
    logic [7:0] txlog [128];

    always #5 clk = ~clk;

    byte_fifo_xfer u0 (
        .clk(clk), .rst_n(rst_n), .bus_width(bus_width), .rd_strobe(rd_strobe),
        .rd_data(rd_data), .wr_strobe(wr_strobe), .wr_data(wr_data),
        .flip_strobe(flip_strobe), .xfer_start(xfer_start), .xfer_write(xfer_write),
        .blk_count(blk_count), .blk_len(blk_len), .card_tx_data(card_tx_data),
        .card_tx_valid(card_tx_valid), .card_tx_ready(card_tx_ready),
        .card_rx_data(card_rx_data), .card_rx_valid(card_rx_valid),
        .card_rx_ready(card_rx_ready), .rx_req(rx_req), .tx_req(tx_req),
        .data_done(data_done), .prog_done(prog_done), .xfer_active(xfer_active)
    );

    // Log card-side transmit bytes and completion pulses.
    always @(posedge clk) begin
        if (rst_n && card_tx_valid && card_tx_ready) begin
            if (txn < 128) txlog[txn] = card_tx_data;
            txn = txn + 1;
        end
        if (rst_n && data_done) dd_cnt = dd_cnt + 1;
        if (rst_n && prog_done) pd_cnt = pd_cnt + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_xfer(input logic wr, input logic [15:0] cnt, input logic [11:0] len);
        xfer_write = wr; blk_count = cnt; blk_len = len; xfer_start = 1'b1;
        tick();
        xfer_start = 1'b0;
    endtask

    task automatic pop(input logic [1:0] w, output logic [31:0] d);
        bus_width = w; rd_strobe = 1'b1;
        tick();
        rd_strobe = 1'b0;
        d = rd_data;
    endtask

    task automatic push(input logic [1:0] w, input logic [31:0] d);
        bus_width = w; wr_data = d; wr_strobe = 1'b1;
        tick();
        wr_strobe = 1'b0;
    endtask

    task automatic feed(input logic [7:0] b, output logic took);
        card_rx_data = b; card_rx_valid = 1'b1;
        took = card_rx_ready;
        tick();
        card_rx_valid = 1'b0;
    endtask

    // Pop patterns after ten bytes 0x10..0x19 are queued: {width code, expected}.
    localparam logic [33:0] POPV [5] = '{
        {2'd2, 32'h10111213},
        {2'd1, 32'h00001415},
        {2'd0, 32'h00000016},
        {2'd3, 32'h17181900},
        {2'd1, 32'h00000000}
    };

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic took;
        int acc, base, d0, p0;

        tick(3);
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 outputs", {27'd0, xfer_active, rx_req, tx_req, data_done, prog_done}, 32'd0);
        chk("R1 card handshake", {30'd0, card_rx_ready, card_tx_valid}, 32'd0);
        pop(2'd2, d);
        chk("R1 empty read", d, 32'd0);

        // R2 pop packing, R5 receive request
        d0 = dd_cnt; p0 = pd_cnt;
        start_xfer(1'b0, 16'd1, 12'd10);
        for (int i = 0; i < 10; i++) feed(8'(8'h10 + i), took);
        chk("R5 rx_req set", {31'd0, rx_req}, 32'd1);
        tick(3);
        chk("R8 read done", 32'(dd_cnt - d0), 32'd1);
        chk("R8 no prog_done on read", 32'(pd_cnt - p0), 32'd0);
        chk("R8 inactive", {31'd0, xfer_active}, 32'd0);
        for (int v = 0; v < 5; v++) begin
            pop(POPV[v][33:32], d);
            chk($sformatf("R2 pop vector %0d", v), d, POPV[v][31:0]);
            if (v == 0) chk("R5 rx_req cleared", {31'd0, rx_req}, 32'd0);
        end

        // R3 receive capacity and wrap
        start_xfer(1'b0, 16'd1, 12'd40);
        acc = 0;
        for (int i = 0; i < 34; i++) begin
            feed(8'(8'h40 + acc), took);
            if (took) acc++;
        end
        chk("R3 accepted at full", 32'(acc), 32'd32);
        chk("R3 ready low at full", {31'd0, card_rx_ready}, 32'd0);
        for (int k = 0; k < 8; k++) begin
            pop(2'd2, d);
            chk("R3 drain order", d, {8'(8'h40 + 4*k), 8'(8'h41 + 4*k), 8'(8'h42 + 4*k), 8'(8'h43 + 4*k)});
        end
        for (int i = 0; i < 8; i++) feed(8'(8'h60 + i), took);
        pop(2'd2, d);
        chk("R3 wrapped bytes", d, 32'h60616263);
        pop(2'd2, d);
        chk("R3 wrapped bytes", d, 32'h64656667);

        // R7 product of count and length
        start_xfer(1'b0, 16'd2, 12'd3);
        acc = 0;
        for (int i = 0; i < 10; i++) begin
            feed(8'(i), took);
            if (took) acc++;
        end
        chk("R7 bytes moved", 32'(acc), 32'd6);

        // R4 write unpacking, R6 transmit request, R8 write done
        card_tx_ready = 1'b1;
        base = txn; d0 = dd_cnt; p0 = pd_cnt;
        start_xfer(1'b1, 16'd1, 12'd6);
        tick();
        chk("R6 tx_req raised", {31'd0, tx_req}, 32'd1);
        push(2'd2, 32'hA1A2A3A4);
        chk("R6 tx_req cleared by write", {31'd0, tx_req}, 32'd0);
        push(2'd1, 32'h0000B1B2);
        tick(8);
        chk("R4 bytes sent", 32'(txn - base), 32'd6);
        chk("R4 order", {txlog[base], txlog[base+1], txlog[base+2], txlog[base+3]}, 32'hA1A2A3A4);
        chk("R4 order half", {16'd0, txlog[base+4], txlog[base+5]}, 32'h0000B1B2);
        chk("R8 write data_done", 32'(dd_cnt - d0), 32'd1);
        chk("R8 write prog_done", 32'(pd_cnt - p0), 32'd1);
        push(2'd0, 32'h000000FF);
        tick(2);
        chk("R6 tx_req stays clear after done", {31'd0, tx_req}, 32'd0);

        // R4 transmit capacity
        card_tx_ready = 1'b0;
        start_xfer(1'b1, 16'd1, 12'd36);
        for (int k = 0; k < 9; k++)
            push(2'd2, {8'(8'h80 + 4*k), 8'(8'h81 + 4*k), 8'(8'h82 + 4*k), 8'(8'h83 + 4*k)});
        base = txn;
        card_tx_ready = 1'b1;
        tick(40);
        chk("R4 stop at 32 queued", 32'(txn - base), 32'd32);
        acc = 0;
        for (int i = 0; i < 32; i++) if (txlog[base+i] != 8'(8'h80 + i)) acc++;
        chk("R4 queued order", 32'(acc), 32'd0);
        chk("R7 tx idle when empty", {30'd0, card_tx_valid, xfer_active}, 32'd1);
        push(2'd2, 32'hE0E1E2E3);
        tick(6);
        chk("R4 refill", {txlog[base+32], txlog[base+33], txlog[base+34], txlog[base+35]}, 32'hE0E1E2E3);
        chk("R8 inactive after write", {31'd0, xfer_active}, 32'd0);

        // R9 half flip
        card_tx_ready = 1'b0;
        start_xfer(1'b1, 16'd1, 12'd4);
        push(2'd2, 32'h11223344);
        chk("R9 queued before flip", {31'd0, card_tx_valid}, 32'd1);
        flip_strobe = 1'b1; tick(); flip_strobe = 1'b0;
        chk("R9 emptied by flip", {31'd0, card_tx_valid}, 32'd0);
        push(2'd2, 32'h55667788);
        base = txn;
        card_tx_ready = 1'b1;
        tick(8);
        chk("R9 bytes after flip", {txlog[base], txlog[base+1], txlog[base+2], txlog[base+3]}, 32'h55667788);
        chk("R9 count after flip", 32'(txn - base), 32'd4);
        card_tx_ready = 1'b0;

        // R10 start empties the queues
        start_xfer(1'b0, 16'd1, 12'd4);
        feed(8'h01, took);
        feed(8'h02, took);
        start_xfer(1'b0, 16'd1, 12'd4);
        pop(2'd2, d);
        chk("R10 receive emptied", d, 32'd0);
        for (int i = 0; i < 4; i++) feed(8'(8'h31 + i), took);
        pop(2'd2, d);
        chk("R10 new bytes only", d, 32'h31323334);

        // R8 zero-length transfer
        tick(3);
        d0 = dd_cnt;
        start_xfer(1'b0, 16'd0, 12'd5);
        tick(3);
        chk("R8 zero length done", 32'(dd_cnt - d0), 32'd1);
        chk("R8 zero length idle", {31'd0, xfer_active}, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule